// File: doc/BRIEF.md
# DRAM Self-Refresh Handshake Controller

This block parks external DRAM in self-refresh before the system drops into a low-power state, and brings it back out on resume. A power sequencer gives it a one-cycle start command. The block then watches the memory controller's status word for a quiet window. It asks for self-refresh with a level bit that only takes effect when a separate one-cycle update strobe is applied. When the controller confirms that self-refresh has begun, the block can turn off the DRAM clock by itself.

A resume command reverses the sequence. The DRAM clock comes back first. The request level is then dropped and strobed again, and the block waits until the controller reports that self-refresh has ended. A one-cycle done pulse marks the end of entry and the end of exit. Every wait has a programmable timeout that aborts to the idle state and raises an error flag. This keeps a missing handshake from hanging the power sequence.

Top module: `srf_handshake_ctrl`

## Requirements
- R1: After a start command accepted in idle, `sref_level` stays low until the block has sampled the busy bit (status bit 0) as 1 on at least one cycle and then as 0. `sref_level` rises in the cycle after that 0 is sampled.
- R2: On entry, `sref_level` is high for one cycle before `sref_update` rises. `sref_update` is high for exactly one cycle, and `sref_level` holds its value across the strobe.
- R3: After the entry strobe, the block waits for the self-refresh bit (status bit 2) to read 1. In the cycle after it is sampled, `seq_done` is high for exactly one cycle and `sref_level` stays high.
- R4: When entry completes with `auto_clk_stop`=1, `dram_clk_en` goes to 0 in the same cycle as the entry done pulse. With `auto_clk_stop`=0 it stays 1.
- R5: A resume command accepted while parked sets `dram_clk_en` to 1 in the next cycle, while `sref_level` is still high. `sref_level` falls one cycle later.
- R6: On exit, `sref_level` goes low. `sref_update` is then pulsed for one cycle with the level held low. The block waits for status bit 2 to read 0, then gives one `seq_done` pulse and returns to idle.
- R7: Status bits other than bit 0 and bit 2 have no effect on the outputs.
- R8: A wait whose condition is unmet on `timeout_limit`+1 consecutive sampled cycles aborts to idle. On abort, `tmo_err`=1, `sref_level`=0, `sref_update`=0 and `dram_clk_en`=1. A condition met on the final sampled cycle wins over the timeout.
- R9: `tmo_err` stays set until the next start command is accepted, and clears in the cycle after that acceptance.
- R10: A start command outside idle and a resume command outside the parked state are ignored.
- R11: Out of reset, `sref_level`=0, `sref_update`=0, `dram_clk_en`=1, `seq_done`=0 and `tmo_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_cmd | input | 1 | One-cycle request to enter self-refresh |
| resume_cmd | input | 1 | One-cycle request to leave self-refresh |
| auto_clk_stop | input | 1 | 1: gate the DRAM clock once self-refresh is confirmed |
| timeout_limit | input | TMO_W | Wait timeout, in cycles, minus one |
| mc_status | input | STAT_W | Memory controller status; bit 0 busy, bit 2 in self-refresh |
| sref_level | output | 1 | Self-refresh request level |
| sref_update | output | 1 | One-cycle strobe that applies the level |
| dram_clk_en | output | 1 | DRAM clock enable |
| seq_done | output | 1 | One-cycle pulse at the end of entry or of exit |
| tmo_err | output | 1 | Sticky timeout error |

## Verification
The interesting collision is a wait condition and the timeout expiry landing on the same clock edge. The bench lets a wait run for exactly `timeout_limit` cycles and then raises busy, or the self-refresh bit, on the final sampled cycle. It expects the sequence to go on with no error. A second run then holds the condition off for one more cycle and expects the abort with idle outputs. A start command arriving while parked, and a resume arriving in idle, are driven as well. The outputs are compared one cycle later to confirm that nothing moved.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int unsigned BUSY_BIT = 0;
  localparam int unsigned SREF_BIT = 2;

  typedef enum logic [3:0] {
    S_IDLE, S_W_BUSY, S_W_QUIET, S_LVL_SET, S_UPD_ON, S_UPD_OFF, S_W_ACK,
    S_PARKED, S_CLK_ON, S_LVL_CLR, S_XUPD_ON, S_XUPD_OFF, S_W_REL
  } srf_state_e;

  // true for the four states that wait on a status condition
  function automatic logic is_wait(srf_state_e s);
    return (s == S_W_BUSY) || (s == S_W_QUIET) || (s == S_W_ACK) || (s == S_W_REL);
  endfunction

  // condition each wait state is looking for
  function automatic logic wait_met(srf_state_e s, logic busy, logic sref);
    case (s)
      S_W_BUSY:  return busy;
      S_W_QUIET: return !busy;
      S_W_ACK:   return sref;
      S_W_REL:   return !sref;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic level_of(srf_state_e s);
    return (s == S_LVL_SET) || (s == S_UPD_ON) || (s == S_UPD_OFF) ||
           (s == S_W_ACK) || (s == S_PARKED) || (s == S_CLK_ON);
  endfunction

  function automatic logic strobe_of(srf_state_e s);
    return (s == S_UPD_ON) || (s == S_XUPD_ON);
  endfunction
endpackage

// File: rtl/srf_status_tap.sv
module srf_status_tap import srf_pkg::*; #(
  parameter int unsigned STAT_W = 8
) (
  input  logic [STAT_W-1:0] status,
  output logic              busy,
  output logic              sref
);
  logic unused_stat_bits;

  assign busy = status[BUSY_BIT];
  assign sref = status[SREF_BIT];
  assign unused_stat_bits = ^status;
endmodule

// File: rtl/srf_wait_timer.sv
module srf_wait_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  assign expired = run && (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart)           cnt_q <= '0;
    else if (run && !expired)   cnt_q <= cnt_q + ONE;
  end

  AST_TMR_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/srf_seq_fsm.sv
module srf_seq_fsm import srf_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic resume,
  input  logic busy,
  input  logic sref,
  input  logic auto_stop,
  input  logic tmo,
  output logic tmr_restart,
  output logic tmr_run,
  output logic sr_level,
  output logic sr_update,
  output logic clk_en,
  output logic done,
  output logic err
);
  srf_state_e state_q, state_d;

  // named internal events
  logic met, ack_seen, rel_seen, tmo_fire, accept_start, accept_resume;

  always_comb begin
    state_d       = state_q;
    met           = wait_met(state_q, busy, sref);
    ack_seen      = 1'b0;
    rel_seen      = 1'b0;
    tmo_fire      = 1'b0;
    accept_start  = 1'b0;
    accept_resume = 1'b0;
    if (is_wait(state_q)) begin
      if (met) begin
        case (state_q)
          S_W_BUSY:  state_d = S_W_QUIET;
          S_W_QUIET: state_d = S_LVL_SET;
          S_W_ACK:   begin state_d = S_PARKED; ack_seen = 1'b1; end
          default:   begin state_d = S_IDLE;   rel_seen = 1'b1; end
        endcase
      end else if (tmo) begin
        tmo_fire = 1'b1;
        state_d  = S_IDLE;
      end
    end else begin
      case (state_q)
        S_IDLE:     if (start)  begin state_d = S_W_BUSY; accept_start = 1'b1; end
        S_LVL_SET:  state_d = S_UPD_ON;
        S_UPD_ON:   state_d = S_UPD_OFF;
        S_UPD_OFF:  state_d = S_W_ACK;
        S_PARKED:   if (resume) begin state_d = S_CLK_ON; accept_resume = 1'b1; end
        S_CLK_ON:   state_d = S_LVL_CLR;
        S_LVL_CLR:  state_d = S_XUPD_ON;
        S_XUPD_ON:  state_d = S_XUPD_OFF;
        S_XUPD_OFF: state_d = S_W_REL;
        default:    state_d = S_IDLE;
      endcase
    end
  end

  assign tmr_restart = (state_d != state_q);
  assign tmr_run     = is_wait(state_q);
  assign sr_level    = level_of(state_q);
  assign sr_update   = strobe_of(state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      clk_en  <= 1'b1;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= ack_seen | rel_seen;
      if (ack_seen && auto_stop)          clk_en <= 1'b0;
      else if (accept_resume || tmo_fire) clk_en <= 1'b1;
      if (tmo_fire)          err <= 1'b1;
      else if (accept_start) err <= 1'b0;
    end
  end

  AST_LVL_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_level) |-> $past(!busy)); // R1
  AST_UPD_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    sr_update |-> $stable(sr_level)); // R2
  AST_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sr_update |=> !sr_update); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_CLK_STOP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en) |-> ($past(sref && auto_stop) && done)); // R4
  AST_CLK_BEFORE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_level) |-> clk_en); // R5
  AST_DONE_MATCHES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(sref) == sr_level)); // R6
  AST_ERR_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (!sr_level && !sr_update && clk_en)); // R8
  AST_ERR_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(start)); // R9
endmodule

// File: rtl/srf_handshake_ctrl.sv
module srf_handshake_ctrl #(
  parameter int unsigned STAT_W = 8,
  parameter int unsigned TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_cmd,
  input  logic              resume_cmd,
  input  logic              auto_clk_stop,
  input  logic [TMO_W-1:0]  timeout_limit,
  input  logic [STAT_W-1:0] mc_status,
  output logic              sref_level,
  output logic              sref_update,
  output logic              dram_clk_en,
  output logic              seq_done,
  output logic              tmo_err
);
  logic st_busy, st_sref;
  logic tmr_restart, tmr_run, tmr_expired;

  srf_status_tap #(.STAT_W(STAT_W)) tap_i (
    .status (mc_status),
    .busy   (st_busy),
    .sref   (st_sref)
  );

  srf_wait_timer #(.CNT_W(TMO_W)) tmr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .run     (tmr_run),
    .limit   (timeout_limit),
    .expired (tmr_expired)
  );

  srf_seq_fsm fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_cmd),
    .resume      (resume_cmd),
    .busy        (st_busy),
    .sref        (st_sref),
    .auto_stop   (auto_clk_stop),
    .tmo         (tmr_expired),
    .tmr_restart (tmr_restart),
    .tmr_run     (tmr_run),
    .sr_level    (sref_level),
    .sr_update   (sref_update),
    .clk_en      (dram_clk_en),
    .done        (seq_done),
    .err         (tmo_err)
  );
endmodule

// File: tb/srf_handshake_ctrl_tb.sv
`timescale 1ns/1ps
module srf_handshake_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_cmd = 1'b0, resume_cmd = 1'b0, auto_clk_stop = 1'b1;
  logic [15:0] timeout_limit = 16'd40;
  logic        busy_b = 1'b0, sref_b = 1'b0, hold_noise = 1'b0;
  logic [7:0]  noise = 8'h00;
  logic [7:0]  mc_status;
  logic        sref_level, sref_update, dram_clk_en, seq_done, tmo_err;
  int          n_tests = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  assign mc_status = {noise[7:3], sref_b, noise[1], busy_b};

  srf_handshake_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .resume_cmd(resume_cmd),
    .auto_clk_stop(auto_clk_stop), .timeout_limit(timeout_limit), .mc_status(mc_status),
    .sref_level(sref_level), .sref_update(sref_update), .dram_clk_en(dram_clk_en),
    .seq_done(seq_done), .tmo_err(tmo_err)
  );

  // expected clock enable while parked
  function automatic int parked_clk(bit autostop);
    return autostop ? 0 : 1;
  endfunction

  // sampled cycles a wait survives before the abort edge
  function automatic int survive_cycles(int limit);
    return limit;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
    if (!hold_noise) noise = 8'($urandom);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp_v);
    n_tests++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  task automatic enter_until_ack(input int d1, input int d2);
    start_cmd = 1'b1; step(); start_cmd = 1'b0;
    chk("R9", "err cleared on start", tmo_err, 0);
    for (int i = 0; i < d1; i++) begin step(); chk("R1", "level before busy", sref_level, 0); end
    busy_b = 1'b1; step(); chk("R1", "level while busy", sref_level, 0);
    for (int i = 1; i < d2; i++) begin step(); chk("R1", "level in busy window", sref_level, 0); end
    busy_b = 1'b0; step();
    chk("R1", "level after quiet", sref_level, 1);
    chk("R2", "update before strobe", sref_update, 0);
    step(); chk("R2", "update strobe", sref_update, 1); chk("R2", "level held", sref_level, 1);
    step(); chk("R2", "update dropped", sref_update, 0); chk("R2", "level after strobe", sref_level, 1);
    step(); chk("R3", "no done before ack", seq_done, 0);
  endtask

  task automatic finish_entry(input bit autostop, input int d3);
    for (int i = 0; i < d3; i++) begin
      step(); chk("R3", "done waiting ack", seq_done, 0); chk("R4", "clk on before ack", dram_clk_en, 1);
    end
    sref_b = 1'b1; step();
    chk("R3", "entry done", seq_done, 1);
    chk("R3", "level parked", sref_level, 1);
    chk("R4", "parked clock", dram_clk_en, parked_clk(autostop));
    step(); chk("R3", "done one cycle", seq_done, 0);
  endtask

  task automatic do_exit(input int d4);
    resume_cmd = 1'b1; step(); resume_cmd = 1'b0;
    chk("R5", "clock restored", dram_clk_en, 1); chk("R5", "level still high", sref_level, 1);
    step(); chk("R6", "level cleared", sref_level, 0); chk("R6", "no strobe yet", sref_update, 0);
    step(); chk("R6", "exit strobe", sref_update, 1); chk("R6", "level low in strobe", sref_level, 0);
    step(); chk("R6", "exit strobe ends", sref_update, 0);
    step();
    for (int i = 0; i < d4; i++) begin step(); chk("R6", "done waiting release", seq_done, 0); end
    sref_b = 1'b0; step();
    chk("R6", "exit done", seq_done, 1); chk("R6", "idle level", sref_level, 0);
    step(); chk("R6", "exit done one cycle", seq_done, 0);
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd1234);
    step(); step();
    chk("R11", "reset level", sref_level, 0);
    chk("R11", "reset update", sref_update, 0);
    chk("R11", "reset clk_en", dram_clk_en, 1);
    chk("R11", "reset done", seq_done, 0);
    chk("R11", "reset err", tmo_err, 0);
    rst_n = 1'b1; step();

    // resume in idle is ignored
    resume_cmd = 1'b1; step(); resume_cmd = 1'b0;
    chk("R10", "resume in idle level", sref_level, 0);
    chk("R10", "resume in idle done", seq_done, 0);
    step(); chk("R10", "still idle update", sref_update, 0);

    // other status bits ignored while waiting for busy
    hold_noise = 1'b1; noise = 8'hFF;
    start_cmd = 1'b1; step(); start_cmd = 1'b0;
    for (int i = 0; i < 4; i++) begin step(); chk("R7", "noise bits", sref_level + sref_update, 0); end
    hold_noise = 1'b0;
    busy_b = 1'b1; step(); busy_b = 1'b0; step();
    chk("R1", "level after short busy", sref_level, 1);
    step(); step(); step();
    finish_entry(1'b1, 2);
    // start while parked is ignored
    start_cmd = 1'b1; step(); start_cmd = 1'b0;
    chk("R10", "start while parked level", sref_level, 1);
    chk("R10", "start while parked clk", dram_clk_en, 0);
    step(); chk("R10", "start while parked update", sref_update, 0);
    do_exit(1);

    // directed, clock stop disabled
    auto_clk_stop = 1'b0;
    enter_until_ack(0, 1); finish_entry(1'b0, 0); do_exit(0);

    // random handshakes
    for (int n = 0; n < 8; n++) begin
      bit a;
      a = 1'($urandom_range(0, 1));
      auto_clk_stop = a;
      enter_until_ack($urandom_range(0, 5), $urandom_range(1, 4));
      finish_entry(a, $urandom_range(0, 5));
      repeat ($urandom_range(0, 3)) step();
      do_exit($urandom_range(0, 5));
    end

    // timeout while waiting for busy
    timeout_limit = 16'd3; auto_clk_stop = 1'b1;
    start_cmd = 1'b1; step(); start_cmd = 1'b0;
    for (int i = 0; i < survive_cycles(3); i++) begin step(); chk("R8", "no early timeout", tmo_err, 0); end
    step();
    chk("R8", "timeout err", tmo_err, 1);
    chk("R8", "abort level", sref_level, 0);
    chk("R8", "abort clk", dram_clk_en, 1);
    step(); step(); chk("R9", "err sticky", tmo_err, 1);

    // condition on the last sampled cycle wins; then ack timeout
    start_cmd = 1'b1; step(); start_cmd = 1'b0;
    chk("R9", "err cleared by start", tmo_err, 0);
    for (int i = 0; i < survive_cycles(3); i++) step();
    busy_b = 1'b1; step();
    chk("R8", "busy on final cycle wins", tmo_err, 0);
    busy_b = 1'b0; step(); chk("R1", "level after last-cycle busy", sref_level, 1);
    step(); step(); step();
    for (int i = 0; i < survive_cycles(3); i++) begin step(); chk("R8", "ack wait alive", sref_level, 1); end
    step();
    chk("R8", "ack timeout err", tmo_err, 1);
    chk("R8", "ack abort level", sref_level, 0);
    chk("R8", "ack abort clk", dram_clk_en, 1);
    chk("R8", "ack abort done", seq_done, 0);

    // recovery after error
    timeout_limit = 16'd40;
    enter_until_ack(1, 2); finish_entry(1'b1, 1); do_exit(2);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule